// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block chooses which of several prioritized interrupt levels gets the processor next. Every level presents a 16-bit status word, in which each bit is raised by an interrupt indicator of one source assigned to that level. A level asks for service when any bit of its word is set. The processor supplies cycle and instruction boundary strobes. The block samples requests into a request register when a machine cycle starts. It acknowledges the best eligible level only at an instruction boundary. When it acknowledges a level, it issues a one-cycle forced-branch request that carries the fixed vector address of that level.

Levels being serviced are recorded in an in-service vector, so service routines can nest. A new request must outrank every level already in service. A branch-out strobe closes the most urgent open service. A sense command returns the status word of the most urgent polled level without naming that level, so service software can find the source. A mask register blocks levels. A masked request is simply not sampled and is still recognized once its level is unmasked.

Top module: `irq_level_ctrl`

## Requirements
- R1: Synchronous reset clears the in-service vector, the request register, the mask, the forced-branch output and the sense data to zero.
- R2: On a clock edge with `cycle_start_i` high and polling open, the request register bit of each level becomes 1 when that level's status word is nonzero and its mask bit is 0. Status changes between poll strobes are not seen by acknowledgement or sense.
- R3: Acknowledgement happens only on an edge where `instr_end_i` is high, or where `idle_i` and `cycle_end_i` are both high.
- R4: No acknowledgement happens on an edge where `ack_block_i` is high.
- R5: A level whose mask bit is 1 (bit i of `mask_wdata_i` masks level i, loaded when `mask_we_i` is high) is never acknowledged. The lowest-index unmasked requesting level is the one chosen.
- R6: Level 0 is the most urgent. A request is acknowledged only when its index is lower than that of every level in service. Acknowledgement sets that level's bit in `in_service_o`.
- R7: After an acknowledging edge, `fbr_valid_o` is high for one cycle, with `fbr_level_o` equal to the level and `fbr_addr_o` equal to `BASE_ADDR` plus the level.
- R8: After an acknowledgement, the next two `cycle_start_i` strobes do not poll. The third one does.
- R9: After an edge with `sense_i` high, `sense_data_o` holds the current status word of the lowest-index level set in the request register, or zero if none is set. Otherwise it holds its value.
- R10: On an edge with `branch_out_i` high, the lowest-index set bit of `in_service_o` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_status_i | input | NUM_LEVELS*16 | Status words, level i at bits [16i+15:16i] |
| mask_we_i | input | 1 | Load the mask register |
| mask_wdata_i | input | NUM_LEVELS | New mask, 1 masks a level |
| cycle_start_i | input | 1 | Start of machine cycle (poll point) |
| cycle_end_i | input | 1 | End of machine cycle |
| instr_end_i | input | 1 | End of instruction |
| idle_i | input | 1 | Processor idle; cycle end acts as instruction end |
| ack_block_i | input | 1 | I/O, branch-and-store or branch-out instruction executing |
| branch_out_i | input | 1 | Return from interrupt; closes the most urgent service |
| sense_i | input | 1 | Sense-level command |
| sense_data_o | output | 16 | Status word returned by the last sense |
| fbr_valid_o | output | 1 | Forced-branch request pulse |
| fbr_level_o | output | $clog2(NUM_LEVELS) | Level being entered |
| fbr_addr_o | output | ADDR_W | Vector address of that level |
| in_service_o | output | NUM_LEVELS | Levels currently in service |

## Verification
The hardest case to reach is a second, more urgent request that arrives while a level is already in service and polling is still closed after the forced branch. The bench acknowledges one level, raises another, and steps the poll strobe exactly three times before the next instruction boundary. It does this for every ordered pair of levels, so both nesting and refusal of equal or less urgent levels are covered. Mask and sense behaviour are swept over all 64 patterns of the six-level default.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    // Poll gate: after an acknowledgement two poll strobes are swallowed
    typedef enum logic [1:0] {
        GATE_OPEN  = 2'd0,
        GATE_SKIP1 = 2'd1,
        GATE_SKIP2 = 2'd2
    } poll_gate_e;

    localparam int STATUS_W = 16;

    function automatic logic is_ack_point(input logic instr_end,
                                          input logic idle,
                                          input logic cycle_end);
        return instr_end | (idle & cycle_end);
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_req_poll.sv
module irq_req_poll
    import irq_lvl_pkg::*;
#(
    parameter int N = 6,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cycle_start_i,
    input  logic           ack_fire_i,
    input  logic [N*W-1:0] status_i,
    input  logic [N-1:0]   mask_i,
    output logic [N-1:0]   req_o
);

    typedef struct packed {
        logic [N-1:0] req;
        poll_gate_e   gate;
    } poll_state_t;

    poll_state_t  st_d, st_q;
    logic [N-1:0] live_req;

    for (genvar g = 0; g < N; g++) begin : g_live
        assign live_req[g] = (|status_i[g*W +: W]) & ~mask_i[g];
    end

    always_comb begin
        st_d = st_q;
        if (cycle_start_i) begin
            unique case (st_q.gate)
                GATE_OPEN:  st_d.req  = live_req;
                GATE_SKIP2: st_d.gate = GATE_SKIP1;
                default:    st_d.gate = GATE_OPEN;
            endcase
        end
        if (ack_fire_i) begin
            st_d.gate = GATE_SKIP2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.req  <= '0;
            st_q.gate <= GATE_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/irq_service_track.sv
module irq_service_track #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_point_i,
    input  logic          ack_block_i,
    input  logic          branch_out_i,
    input  logic [N-1:0]  elig_req_i,
    output logic          fire_o,
    output logic [IW-1:0] fire_level_o,
    output logic [N-1:0]  in_service_o
);

    typedef struct packed {
        logic [N-1:0] ins;
    } svc_state_t;

    svc_state_t    st_d, st_q;
    logic          req_found, ins_found;
    logic [IW-1:0] req_idx, ins_idx;

    irq_prio_enc #(.N(N), .IW(IW)) u_req_enc (
        .vec_i   (elig_req_i),
        .found_o (req_found),
        .idx_o   (req_idx)
    );

    irq_prio_enc #(.N(N), .IW(IW)) u_ins_enc (
        .vec_i   (st_q.ins),
        .found_o (ins_found),
        .idx_o   (ins_idx)
    );

    always_comb begin
        fire_o = ack_point_i & ~ack_block_i & req_found &
                 (~ins_found | (req_idx < ins_idx));
        st_d = st_q;
        if (branch_out_i && ins_found) begin
            st_d.ins[ins_idx] = 1'b0;
        end
        if (fire_o) begin
            st_d.ins[req_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ins <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_level_o = req_idx;
    assign in_service_o = st_q.ins;

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int          NUM_LEVELS = 6,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_ADDR  = 16'h0008
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_LEVELS*STATUS_W-1:0] lvl_status_i,
    input  logic                           mask_we_i,
    input  logic [NUM_LEVELS-1:0]          mask_wdata_i,
    input  logic                           cycle_start_i,
    input  logic                           cycle_end_i,
    input  logic                           instr_end_i,
    input  logic                           idle_i,
    input  logic                           ack_block_i,
    input  logic                           branch_out_i,
    input  logic                           sense_i,
    output logic [STATUS_W-1:0]            sense_data_o,
    output logic                           fbr_valid_o,
    output logic [$clog2(NUM_LEVELS)-1:0]  fbr_level_o,
    output logic [ADDR_W-1:0]              fbr_addr_o,
    output logic [NUM_LEVELS-1:0]          in_service_o
);

    localparam int LVL_W = $clog2(NUM_LEVELS);

    typedef struct packed {
        logic [NUM_LEVELS-1:0] mask;
        logic                  fbr_valid;
        logic [LVL_W-1:0]      fbr_level;
        logic [ADDR_W-1:0]     fbr_addr;
        logic [STATUS_W-1:0]   sense;
    } top_state_t;

    top_state_t            st_d, st_q;
    logic [NUM_LEVELS-1:0] req_q;
    logic                  fire;
    logic [LVL_W-1:0]      fire_level;
    logic                  sense_found;
    logic [LVL_W-1:0]      sense_idx;

    irq_req_poll #(.N(NUM_LEVELS), .W(STATUS_W)) u_poll (
        .clk           (clk),
        .rst           (rst),
        .cycle_start_i (cycle_start_i),
        .ack_fire_i    (fire),
        .status_i      (lvl_status_i),
        .mask_i        (st_q.mask),
        .req_o         (req_q)
    );

    irq_service_track #(.N(NUM_LEVELS), .IW(LVL_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .ack_point_i  (is_ack_point(instr_end_i, idle_i, cycle_end_i)),
        .ack_block_i  (ack_block_i),
        .branch_out_i (branch_out_i),
        .elig_req_i   (req_q & ~st_q.mask),
        .fire_o       (fire),
        .fire_level_o (fire_level),
        .in_service_o (in_service_o)
    );

    irq_prio_enc #(.N(NUM_LEVELS), .IW(LVL_W)) u_sense_enc (
        .vec_i   (req_q),
        .found_o (sense_found),
        .idx_o   (sense_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.fbr_valid = fire;
        if (fire) begin
            st_d.fbr_level = fire_level;
            st_d.fbr_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(fire_level);
        end
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
        if (sense_i) begin
            st_d.sense = sense_found ? lvl_status_i[sense_idx*STATUS_W +: STATUS_W]
                                     : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sense_data_o = st_q.sense;
    assign fbr_valid_o  = st_q.fbr_valid;
    assign fbr_level_o  = st_q.fbr_level;
    assign fbr_addr_o   = st_q.fbr_addr;

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NUM_LEVELS = 6,
    parameter int LVL_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  instr_end_i,
    input logic                  idle_i,
    input logic                  cycle_end_i,
    input logic                  ack_block_i,
    input logic                  branch_out_i,
    input logic                  fbr_valid_o,
    input logic [LVL_W-1:0]      fbr_level_o,
    input logic [NUM_LEVELS-1:0] in_service_o
);

    p_ack_point_r3: assert property (@(posedge clk) disable iff (rst)
        fbr_valid_o |-> $past(instr_end_i || (idle_i && cycle_end_i)));

    p_ack_block_r4: assert property (@(posedge clk) disable iff (rst)
        fbr_valid_o |-> !$past(ack_block_i));

    p_level_in_service_r7: assert property (@(posedge clk) disable iff (rst)
        fbr_valid_o |-> in_service_o[fbr_level_o]);

    p_new_bit_needs_ack_r6: assert property (@(posedge clk) disable iff (rst)
        ((in_service_o & ~$past(in_service_o)) != '0) |-> fbr_valid_o);

    p_one_new_bit_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(in_service_o & ~$past(in_service_o)) <= 1);

    p_branch_out_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (branch_out_i && (in_service_o != '0) &&
         !(instr_end_i || (idle_i && cycle_end_i)))
        |=> ($countones(in_service_o) + 1 == $countones($past(in_service_o))));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_end_i  (instr_end_i),
    .idle_i       (idle_i),
    .cycle_end_i  (cycle_end_i),
    .ack_block_i  (ack_block_i),
    .branch_out_i (branch_out_i),
    .fbr_valid_o  (fbr_valid_o),
    .fbr_level_o  (fbr_level_o),
    .in_service_o (in_service_o)
);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;

    localparam int NL   = 6;
    localparam int BASE = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [15:0]    st [NL];
    logic [NL*16-1:0] st_flat;
    logic           mask_we, cycle_start, cycle_end, instr_end, idle;
    logic           ack_block, branch_out, sense;
    logic [NL-1:0]  mask_wdata;
    logic [15:0]    sense_data;
    logic           fbr_valid;
    logic [2:0]     fbr_level;
    logic [15:0]    fbr_addr;
    logic [NL-1:0]  in_service;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) st_flat[i*16 +: 16] = st[i];
    end

    irq_level_ctrl u_dut (
        .clk (clk), .rst (rst), .lvl_status_i (st_flat),
        .mask_we_i (mask_we), .mask_wdata_i (mask_wdata),
        .cycle_start_i (cycle_start), .cycle_end_i (cycle_end),
        .instr_end_i (instr_end), .idle_i (idle), .ack_block_i (ack_block),
        .branch_out_i (branch_out), .sense_i (sense),
        .sense_data_o (sense_data), .fbr_valid_o (fbr_valid),
        .fbr_level_o (fbr_level), .fbr_addr_o (fbr_addr),
        .in_service_o (in_service)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mask_we = 0; cycle_start = 0; cycle_end = 0; instr_end = 0; idle = 0;
        ack_block = 0; branch_out = 0; sense = 0; mask_wdata = '0;
        for (int i = 0; i < NL; i++) st[i] = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic poll();       cycle_start = 1; tick(); cycle_start = 0; endtask
    task automatic end_instr();  instr_end = 1;   tick(); instr_end = 0;   endtask
    task automatic do_sense();   sense = 1;       tick(); sense = 0;       endtask
    task automatic do_bout();    branch_out = 1;  tick(); branch_out = 0;  endtask
    task automatic set_mask(input logic [NL-1:0] m);
        mask_we = 1; mask_wdata = m; tick(); mask_we = 0;
    endtask

    function automatic int lowest(input int v);
        for (int i = 0; i < NL; i++) if ((v >> i) & 1) return i;
        return -1;
    endfunction

    function automatic logic [15:0] word_of(input int lvl, input int salt);
        return 16'h8000 | 16'((salt << 4) | lvl);
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check(in_service == '0, "R1 in_service", in_service, 0);
        check(fbr_valid == 1'b0, "R1 fbr_valid", fbr_valid, 0);
        check(sense_data == '0, "R1 sense_data", sense_data, 0);
        do_sense();
        check(sense_data == '0, "R1 request register empty", sense_data, 0);

        // R5 and R7: every mask pattern with all levels requesting
        for (int m = 0; m < 64; m++) begin
            int exp_l;
            do_reset();
            for (int i = 0; i < NL; i++) st[i] = word_of(i, m);
            set_mask(NL'(m));
            poll();
            end_instr();
            exp_l = lowest((~m) & 63);
            if (exp_l < 0) begin
                check(fbr_valid == 0, "R5 all masked no ack", fbr_valid, 0);
                check(in_service == '0, "R5 all masked in_service", in_service, 0);
            end else begin
                check(fbr_valid == 1 && int'(fbr_level) == exp_l,
                      "R5 chosen level", fbr_level, exp_l);
                check(int'(fbr_addr) == BASE + exp_l, "R7 vector address", fbr_addr, BASE + exp_l);
                check(int'(in_service) == (1 << exp_l), "R6 in_service set", in_service, 1 << exp_l);
                tick();
                check(fbr_valid == 0, "R7 single-cycle pulse", fbr_valid, 0);
            end
        end

        // R9: sense over every request pattern
        for (int p = 0; p < 64; p++) begin
            int exp_l;
            do_reset();
            for (int i = 0; i < NL; i++) st[i] = ((p >> i) & 1) ? word_of(i, p) : 16'h0;
            poll();
            do_sense();
            exp_l = lowest(p);
            check(sense_data == (exp_l < 0 ? 16'h0 : word_of(exp_l, p)),
                  "R9 sense word", sense_data, exp_l < 0 ? 0 : word_of(exp_l, p));
            st[0] = 16'h0001;
            tick();
            check(sense_data == (exp_l < 0 ? 16'h0 : word_of(exp_l, p)),
                  "R9 sense holds", sense_data, exp_l < 0 ? 0 : word_of(exp_l, p));
        end

        // R2: status changes between poll strobes are invisible
        do_reset();
        st[4] = 16'h0040;
        poll();
        st[1] = 16'h0002;
        do_sense();
        check(sense_data == 16'h0040, "R2 unpolled change hidden", sense_data, 16'h0040);
        poll();
        do_sense();
        check(sense_data == 16'h0002, "R2 polled change seen", sense_data, 16'h0002);

        // R3: ack points
        do_reset();
        st[2] = 16'h0100;
        poll();
        cycle_end = 1; tick(); cycle_end = 0;
        check(fbr_valid == 0, "R3 cycle end while busy", fbr_valid, 0);
        tick();
        check(fbr_valid == 0 && in_service == '0, "R3 no boundary", in_service, 0);
        idle = 1; cycle_end = 1; tick(); cycle_end = 0; idle = 0;
        check(fbr_valid == 1 && fbr_level == 3'd2, "R3 idle cycle end acks", fbr_level, 2);

        // R4: blocking instruction
        do_reset();
        st[4] = 16'h0010;
        poll();
        ack_block = 1; instr_end = 1; tick(); ack_block = 0; instr_end = 0;
        check(fbr_valid == 0 && in_service == '0, "R4 blocked", in_service, 0);
        end_instr();
        check(fbr_valid == 1 && fbr_level == 3'd4, "R4 unblocked ack", fbr_level, 4);

        // R6 and R8: every ordered pair of levels
        for (int a = 0; a < NL; a++) begin
            for (int b = 0; b < NL; b++) begin
                int exp_ins;
                do_reset();
                st[a] = word_of(a, 1);
                poll();
                end_instr();
                st[b] = word_of(b, 2);
                poll(); poll();
                end_instr();
                check(in_service == NL'(1 << a), "R8 poll closed after ack", in_service, 1 << a);
                poll();
                end_instr();
                exp_ins = (1 << a) | ((b < a) ? (1 << b) : 0);
                check(int'(in_service) == exp_ins, "R6 nesting", in_service, exp_ins);
                check(fbr_valid == (b < a), "R6 nested ack pulse", fbr_valid, b < a);
            end
        end

        // R8: sense sees the gate
        do_reset();
        st[3] = 16'h0300;
        poll();
        end_instr();
        st[1] = 16'h0111;
        poll();
        do_sense();
        check(sense_data == 16'h0300, "R8 first skipped poll", sense_data, 16'h0300);
        poll();
        do_sense();
        check(sense_data == 16'h0300, "R8 second skipped poll", sense_data, 16'h0300);
        poll();
        do_sense();
        check(sense_data == 16'h0111, "R8 third poll opens", sense_data, 16'h0111);

        // R10: branch-out closes the most urgent service
        end_instr();
        check(in_service == 6'b001010, "R10 setup nested", in_service, 6'b001010);
        do_bout();
        check(in_service == 6'b001000, "R10 inner level closed", in_service, 6'b001000);
        do_bout();
        check(in_service == '0, "R10 outer level closed", in_service, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule